// File: doc/BRIEF.md
# Character Row Address Counter

This block produces the screen-memory address used while a display controller walks across the character cells of a text matrix. A free-running address counter advances once per clock while its active-low enable is held low. The enable stays low for the full visible width of each scan line. The lowest counter bit moves at the clock rate, and bit 1 moves once per character cell, so the cell address is the counter without its bit 0.

A companion register remembers where the current text row began. A store strobe saves the running count into that register. A load strobe puts the saved value back into the counter, so the same row of cells can be fetched again for each pixel line of a character. A vertical-sync pulse zeroes the saved value, which makes the next restore start the frame at address zero. The block does not decide when to store or load: it acts only on the strobes it receives.

Top module: `vmatrix_addr_gen`

## Requirements
- R1: A synchronous active-high reset sets the counter to 0 and the row-start register to 0. A load issued right after reset therefore gives a count of 0.
- R2: When load is low, the counter rises by exactly 1 on each clock while inc_n is 0, and holds its value while inc_n is 1.
- R3: An increment from the all-ones value (0xFFF at the default width) wraps the counter to 0.
- R4: A store pulse copies the counter's present value into the row-start register. A later load shows that value on count.
- R5: A load pulse copies the row-start register into the counter. Load takes priority over an increment in the same cycle.
- R6: When store and load are high in the same cycle, the register captures the count from before the load, and the counter takes the register's old value.
- R7: A vsync_clr pulse sets the row-start register to 0. It wins over a store in the same cycle and does not change the counter.
- R8: cell_addr always equals count bits [ADDR_W-1:1], and count bit 0 toggles on every increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inc_n | input | 1 | Increment enable, active low |
| store | input | 1 | Save the count into the row-start register |
| load | input | 1 | Restore the row-start register into the count |
| vsync_clr | input | 1 | Zero the row-start register |
| count | output | ADDR_W (12) | Current counter value |
| cell_addr | output | ADDR_W-1 (11) | Cell address, count[ADDR_W-1:1] |

## Verification
The bench uses the default ADDR_W of 12. At that width, a run of 4095 increments reaches the all-ones value, so the wrap to zero (R3) is tested directly and not inferred. The table-driven part steps through save, restore, and replay sequences. It covers the collisions between strobes: load against increment, store against load, and clear against store. The contents of the row-start register are only visible through a later load, and that is how the bench observes them.

// File: rtl/vmc_pkg.sv
package vmc_pkg;
  localparam int unsigned DEF_ADDR_W = 12;

  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_STEP = 2'd1,
    CNT_LOAD = 2'd2
  } cnt_op_e;
endpackage

// File: rtl/vmc_addr_counter.sv
module vmc_addr_counter
  import vmc_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  cnt_op_e           op,
  input  logic [ADDR_W-1:0] restore_val,
  output logic [ADDR_W-1:0] cnt_q
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      unique case (op)
        CNT_LOAD: cnt_q <= restore_val;
        CNT_STEP: cnt_q <= cnt_q + ONE;
        default:  cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/vmc_row_latch.sv
module vmc_row_latch #(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              capture,
  input  logic [ADDR_W-1:0] cnt_in,
  output logic [ADDR_W-1:0] row_q
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      row_q <= '0;
    end else if (capture) begin
      row_q <= cnt_in;
    end
  end
endmodule

// File: rtl/vmatrix_addr_gen.sv
module vmatrix_addr_gen
  import vmc_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc_n,
  input  logic              store,
  input  logic              load,
  input  logic              vsync_clr,
  output logic [ADDR_W-1:0] count,
  output logic [ADDR_W-2:0] cell_addr
);
  localparam int unsigned CELL_W = ADDR_W - 1;

  cnt_op_e           op;
  logic [ADDR_W-1:0] row_start;
  logic [ADDR_W-1:0] cnt_q;

  // Load has priority over an increment.
  always_comb begin
    if (load)        op = CNT_LOAD;
    else if (!inc_n) op = CNT_STEP;
    else             op = CNT_HOLD;
  end

  vmc_addr_counter #(.ADDR_W(ADDR_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .op          (op),
    .restore_val (row_start),
    .cnt_q       (cnt_q)
  );

  // The register samples the pre-edge count, so store+load saves the old value.
  vmc_row_latch #(.ADDR_W(ADDR_W)) u_row (
    .clk     (clk),
    .rst     (rst),
    .clr     (vsync_clr),
    .capture (store),
    .cnt_in  (cnt_q),
    .row_q   (row_start)
  );

  assign count     = cnt_q;
  assign cell_addr = cnt_q[ADDR_W-1 -: CELL_W];
endmodule

// File: rtl/vmc_checker.sv
module vmc_checker #(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              inc_n,
  input logic              store,
  input logic              load,
  input logic              vsync_clr,
  input logic [ADDR_W-1:0] count,
  input logic [ADDR_W-1:0] latch_q
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (count == '0 && latch_q == '0));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!load && inc_n) |=> $stable(count));

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!load && !inc_n) |=> count == ADDR_W'($past(count) + 1'b1));

  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (!load && !inc_n && (&count)) |=> count == '0);

  p_store_r4: assert property (@(posedge clk) disable iff (rst)
    (store && !vsync_clr) |=> latch_q == $past(count));

  p_load_r5: assert property (@(posedge clk) disable iff (rst)
    load |=> count == $past(latch_q));

  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    vsync_clr |=> latch_q == '0);

  p_bit0_r8: assert property (@(posedge clk) disable iff (rst)
    (!load && !inc_n) |=> count[0] != $past(count[0]));
endmodule

bind vmatrix_addr_gen vmc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .inc_n     (inc_n),
  .store     (store),
  .load      (load),
  .vsync_clr (vsync_clr),
  .count     (count),
  .latch_q   (row_start)
);

// File: tb/vmatrix_addr_gen_tb.sv
module vmatrix_addr_gen_tb;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned NVEC   = 17;

  logic              clk = 1'b0;
  logic              rst;
  logic              inc_n;
  logic              store;
  logic              load;
  logic              vsync_clr;
  logic [ADDR_W-1:0] count;
  logic [ADDR_W-2:0] cell_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  vmatrix_addr_gen #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .inc_n(inc_n), .store(store),
    .load(load), .vsync_clr(vsync_clr), .count(count), .cell_addr(cell_addr)
  );

  // Vector: {inc_n, store, load, vsync_clr, expected count after the edge}
  localparam logic [15:0] VEC [NVEC] = '{
    {4'b0000, 12'd1},  // R2 step
    {4'b0000, 12'd2},  // R2
    {4'b0000, 12'd3},  // R2, R8
    {4'b1100, 12'd3},  // R4 store 3, R2 hold
    {4'b0000, 12'd4},
    {4'b0000, 12'd5},
    {4'b1010, 12'd3},  // R5 restore
    {4'b0010, 12'd3},  // R5 load beats increment
    {4'b0000, 12'd4},
    {4'b1110, 12'd3},  // R6 old latch in, latch becomes 4
    {4'b1010, 12'd4},  // R6 latch holds pre-load count
    {4'b0001, 12'd5},  // R7 clear, counter still steps
    {4'b1010, 12'd0},  // R7 latch was cleared
    {4'b0000, 12'd1},
    {4'b1101, 12'd1},  // R7 clear beats store
    {4'b1010, 12'd0},  // R7
    {4'b1000, 12'd0}   // R2 hold
  };

  task automatic check(input string req, input logic [ADDR_W-1:0] exp);
    checks++;
    if (count !== exp || cell_addr !== exp[ADDR_W-1:1]) begin
      errors++;
      $display("FAIL %s count=%0h cell=%0h expected count=%0h cell=%0h",
               req, count, cell_addr, exp, exp[ADDR_W-1:1]);
    end
  endtask

  task automatic step(input logic [3:0] ctl);
    {inc_n, store, load, vsync_clr} = ctl;
    @(negedge clk);
  endtask

  initial begin
    #1600000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; inc_n = 1'b1; store = 1'b0; load = 1'b0; vsync_clr = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R1", '0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][15:12]);
      check("R2/R4/R5/R6/R7/R8 table", VEC[i][11:0]);
    end

    // R3: wrap from all ones
    step(4'b1010);  // restore latch (0)
    check("R3 start", '0);
    for (int i = 0; i < 4095; i++) step(4'b0000);
    check("R3 all ones", 12'hFFF);
    step(4'b0000);
    check("R3 wrap", '0);

    // R1: reset clears a saved row start
    for (int i = 0; i < 9; i++) step(4'b0000);
    step(4'b1100);  // store 9
    step(4'b1010);
    check("R4 store 9", 12'd9);
    rst = 1'b1;
    step(4'b1000);
    check("R1 counter", '0);
    rst = 1'b0;
    step(4'b0000);
    step(4'b1010);
    check("R1 latch", '0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule